// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

The block gathers 32 level-sensitive interrupt request lines and turns them into two CPU interrupt lines. Each request line is sampled into a flop on every clock. A per-source enable mask is changed only through two strobe offsets: one sets bits and one clears them. A per-source routing bit sends each enabled, pending source either to the primary line or to the secondary line. The topmost enable bit also serves as a master gate: while it is clear, nothing reaches either line.

Software uses a simple register bus. A valid strobe qualifies each access and a write flag marks the access as a write. Read data is combinational and appears in the same cycle as the strobe. Along with the primary line, the block outputs the index of the lowest-numbered pending primary source and a flag that marks the index as meaningful. A handler can service that source directly. It acknowledges the source by masking it, because a request stays pending for as long as its input is held high.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: The raw view (byte offset 0x30) returns `irq_in` as sampled at the previous clock edge, whatever the enable, routing or gate state.
- R2: A write to offset 0x34 sets every enable bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R3: A write to offset 0x38 clears every enable bit whose data bit is 1, and writing 0xFFFFFFFF clears the whole mask.
- R4: A read of offset 0x34 and a read of offset 0x38 both return the current enable mask.
- R5: The routing register at offset 0x20 can be written and read back. A routing bit of 0 sends an enabled, pending source to the primary view (offset 0x00) and `cpu_irq0`. A routing bit of 1 sends it to the secondary view (offset 0x04) and `cpu_irq1`. No source shows in both views.
- R6: While enable bit 31 is 0, both status views read zero and both CPU lines are low.
- R7: A source stays pending while its input is high. It stops being pending one cycle after its input falls, and at once when its enable bit is cleared.
- R8: `pri_idx` gives the lowest set bit of the primary view. `pri_valid` is high exactly when the primary view is nonzero, and `pri_idx` is 0 when that view is empty.
- R9: Writes to offsets 0x00, 0x04 and 0x30 change no state.
- R10: After reset, the enable mask and the routing register are zero and both CPU lines are low.
- R11: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level request lines, one per source |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| cpu_irq0 | output | 1 | Primary CPU interrupt line |
| cpu_irq1 | output | 1 | Secondary CPU interrupt line |
| pri_idx | output | 5 | Lowest pending primary source |
| pri_valid | output | 1 | Primary view nonzero |

## Verification
The assertions check the following on every cycle:
- the set and clear strobes change only the bits they name;
- routing writes land in the routing register;
- no source appears in both views;
- both lines are silent while the master gate is off;
- `pri_valid` tracks the primary line;
- `pri_idx` points at a set bit that has no lower set bit below it.

The read-back behaviour needs the bench's scenarios, which drive request patterns and register settings. These cover the raw view, the mask seen through both enable offsets, writes ignored at read-only offsets, zero from unmapped offsets, and deassertion of a level request.

// File: rtl/lic_pkg.sv
package lic_pkg;
    parameter int unsigned NSRC = 32;
    parameter int unsigned AW   = 8;
    localparam int unsigned IDXW = $clog2(NSRC);
    localparam int unsigned GBIT = NSRC - 1;

    localparam logic [AW-1:0] OFS_STAT0 = 8'h00;
    localparam logic [AW-1:0] OFS_STAT1 = 8'h04;
    localparam logic [AW-1:0] OFS_ROUTE = 8'h20;
    localparam logic [AW-1:0] OFS_RAW   = 8'h30;
    localparam logic [AW-1:0] OFS_ESET  = 8'h34;
    localparam logic [AW-1:0] OFS_ECLR  = 8'h38;

    typedef struct packed {
        logic [NSRC-1:0] raw;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] route;
    } lic_state_t;
endpackage

// File: rtl/lic_regs.sv
module lic_regs
    import lic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] route
);
    lic_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.raw = irq_in;
        if (wr_en) begin
            case (addr)
                OFS_ROUTE: st_d.route = wdata;
                OFS_ESET:  st_d.en    = st_q.en | wdata;
                OFS_ECLR:  st_d.en    = st_q.en & ~wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw   = st_q.raw;
    assign en    = st_q.en;
    assign route = st_q.route;

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == OFS_ESET) |-> ((en & $past(wdata)) == $past(wdata)));
    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == OFS_ESET) |-> ((en & ~$past(wdata)) == ($past(en) & ~$past(wdata))));
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == OFS_ECLR) |-> ((en & $past(wdata)) == '0));
    p_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == OFS_ROUTE) |-> (route == $past(wdata)));
    p_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (addr == OFS_STAT0 || addr == OFS_STAT1 || addr == OFS_RAW))
        |-> ($stable(en) && $stable(route)));
endmodule

// File: rtl/lic_route.sv
module lic_route
    import lic_pkg::*;
(
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] route,
    output logic [NSRC-1:0] stat0,
    output logic [NSRC-1:0] stat1,
    output logic            line0,
    output logic            line1
);
    logic gate;
    assign gate = en[GBIT];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic live;
        assign live     = raw[i] & en[i] & gate;
        assign stat0[i] = live & ~route[i];
        assign stat1[i] = live &  route[i];
    end

    assign line0 = |stat0;
    assign line1 = |stat1;
endmodule

// File: rtl/lic_prio.sv
module lic_prio
    import lic_pkg::*;
(
    input  logic [NSRC-1:0] vec,
    output logic [IDXW-1:0] idx,
    output logic            valid
);
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDXW'(i);
        end
    end
    assign valid = |vec;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            cpu_irq0,
    output logic            cpu_irq1,
    output logic [IDXW-1:0] pri_idx,
    output logic            pri_valid
);
    logic [NSRC-1:0] raw, en, route, stat0, stat1;
    logic            wr_en, rd_en;

    assign wr_en = bus_valid &  bus_write;
    assign rd_en = bus_valid & ~bus_write;

    lic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .addr(bus_addr), .wdata(bus_wdata), .raw(raw), .en(en), .route(route)
    );

    lic_route u_route (
        .raw(raw), .en(en), .route(route), .stat0(stat0), .stat1(stat1),
        .line0(cpu_irq0), .line1(cpu_irq1)
    );

    lic_prio u_prio (.vec(stat0), .idx(pri_idx), .valid(pri_valid));

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                OFS_STAT0:          bus_rdata = stat0;
                OFS_STAT1:          bus_rdata = stat1;
                OFS_ROUTE:          bus_rdata = route;
                OFS_RAW:            bus_rdata = raw;
                OFS_ESET, OFS_ECLR: bus_rdata = en;
                default:            bus_rdata = '0;
            endcase
        end
    end

    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en[GBIT] |-> (!cpu_irq0 && !cpu_irq1));
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 & stat1) == '0);
    p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pri_valid == cpu_irq0);
    p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pri_valid |-> (stat0[pri_idx] &&
            ((stat0 & ((NSRC'(1) << pri_idx) - NSRC'(1))) == '0)));
    p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & en & ~route & {NSRC{en[GBIT]}}) != '0 |-> cpu_irq0);
endmodule

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] irq_in = '0;
    logic        bus_valid = 0, bus_write = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq0, cpu_irq1, pri_valid;
    logic [4:0]  pri_idx;

    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lvl_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1),
        .pri_idx(pri_idx), .pri_valid(pri_valid)
    );

    // columns: irq, enable, route, primary, secondary, {valid, idx}
    localparam logic [31:0] VEC [6][6] = '{
        '{32'h0000_00F0, 32'h8000_00FF, 32'h0000_0030, 32'h0000_00C0, 32'h0000_0030, 32'h106},
        '{32'hFFFF_FFFF, 32'h8000_0001, 32'h0000_0000, 32'h8000_0001, 32'h0000_0000, 32'h100},
        '{32'h0000_0100, 32'h0000_0100, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h000},
        '{32'h0001_0000, 32'h8001_0000, 32'h0001_0000, 32'h0000_0000, 32'h0001_0000, 32'h000},
        '{32'hA000_0000, 32'hA000_0000, 32'h0000_0000, 32'hA000_0000, 32'h0000_0000, 32'h11D},
        '{32'h0000_0006, 32'h8000_0004, 32'h0000_0000, 32'h0000_0004, 32'h0000_0000, 32'h102}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        rd(8'h34, v); chk("R10 enable", v, 0);
        rd(8'h20, v); chk("R10 route", v, 0);
        chk("R10 lines", {cpu_irq0, cpu_irq1}, 0);

        // table walk: R5 R6 R8 R1
        foreach (VEC[k]) begin
            wr(8'h38, 32'hFFFF_FFFF);
            wr(8'h34, VEC[k][1]);
            wr(8'h20, VEC[k][2]);
            irq_in = VEC[k][0];
            @(negedge clk);
            rd(8'h00, v); chk("R5 primary", v, VEC[k][3]);
            rd(8'h04, v); chk("R5 secondary", v, VEC[k][4]);
            rd(8'h30, v); chk("R1 raw", v, VEC[k][0]);
            chk("R6 lines", {cpu_irq0, cpu_irq1}, {|VEC[k][3], |VEC[k][4]});
            chk("R8 index", {pri_valid, pri_idx}, {VEC[k][5][8], VEC[k][5][4:0]});
        end
        rd(8'h20, v); chk("R5 route readback", v, 0);

        // R2 set keeps zero bits, R3 clear, R4 both offsets
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h34, v); chk("R3 clear all", v, 0);
        wr(8'h34, 32'h3);
        wr(8'h34, 32'h4);
        rd(8'h34, v); chk("R2 set keeps", v, 32'h7);
        wr(8'h38, 32'h2);
        rd(8'h38, v); chk("R4 clear offset read", v, 32'h5);
        rd(8'h34, v); chk("R3 partial clear", v, 32'h5);

        // R9 writes to read-only offsets
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h34, v); chk("R9 enable untouched", v, 32'h5);
        rd(8'h20, v); chk("R9 route untouched", v, 0);

        // R11 unmapped offset
        rd(8'h10, v); chk("R11 unmapped", v, 0);

        // R7 level behaviour
        wr(8'h34, 32'h8000_0010);
        irq_in = 32'h0000_0010;
        @(negedge clk);
        chk("R7 pending", {cpu_irq0, pri_idx}, {1'b1, 5'd4});
        @(negedge clk);
        chk("R7 stays", cpu_irq0, 1);
        irq_in = 0;
        @(negedge clk);
        chk("R7 input drop", cpu_irq0, 0);
        irq_in = 32'h0000_0010;
        @(negedge clk);
        wr(8'h38, 32'h0000_0010);
        chk("R7 mask ack", {cpu_irq0, pri_valid}, 0);
        rd(8'h30, v); chk("R1 raw while masked", v, 32'h10);

        // R6 gate off with enabled source
        wr(8'h34, 32'h0000_0010);
        wr(8'h38, 32'h8000_0000);
        rd(8'h00, v); chk("R6 gate off", v, 0);

        // R10 reset mid-run
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        rd(8'h34, v); chk("R10 enable after reset", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule